// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Generator

This block makes the four switch-enable signals for a full-bridge inverter that has two legs, A and B. Each leg drives a high-side and a low-side switch at 50% command duty, and both legs share one switching period. Leg B lags leg A by a commanded number of clock cycles. The lag sets the net voltage across the bridge. A lag of zero puts the legs in phase, so there is no net drive. A lag of half the period puts them in opposition, which gives full drive.

A controller supplies three words: the period in clock cycles, the phase lag in clock cycles, and the dead time in clock cycles. The block reads these words only at the boundary of a leg-A period, so it never cuts a pulse short. Whenever a leg changes state, both of its switches are held off for the dead time before the complementary switch turns on. The low-side on-interval of a leg is also the window in which that leg's high-side supply recharges.

After enable rises, the first period always runs at the shortest period allowed, which is the highest frequency. The controller can then walk the period up toward the longest period allowed, about 2.4 times the shortest. Dropping enable stops all switching and clears the internal state.

Top module: `psfb_gate_gen`

## Requirements
- R1: All four outputs are low while `rst` is high and from the first clock edge at which `en` is sampled low. While `en` stays low, changes on the word inputs leave all outputs low.
- R2: Both legs switch at one common period P. Consecutive rising edges of `a_hi_o` are exactly P cycles apart, and so are consecutive rising edges of `b_hi_o`.
- R3: P is the value on `period_i` limited to the range 20 to 48 cycles (PER_MIN to PER_MAX = PER_MIN*12/5).
- R4: The first period after `en` rises lasts PER_MIN cycles, whatever the value of `period_i`. Later periods follow `period_i`.
- R5: The period, phase and dead-time words are captured only when a leg-A period ends. A change made partway through a period first shows in the next period, and the current period completes with the old values.
- R6: Each rising edge of `b_hi_o` comes exactly PH cycles after the latest rising edge of `a_hi_o`. PH is `phase_i` limited to floor(P/2). PH = 0 puts the legs in phase.
- R7: The dead time D is `dead_i` limited to the range 1 to 7 cycles. In each leg the low-side turns on exactly D cycles after the high-side turns off, and the high-side turns on exactly D cycles after the low-side turns off.
- R8: In each leg the high-side stays on for floor(P/2) - D cycles per period, and the low-side stays on for P - floor(P/2) - D cycles per period.
- R9: Within a leg the high-side and low-side outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low stops switching and clears state |
| period_i | input | CNT_W (8) | Switching period in clock cycles |
| phase_i | input | CNT_W (8) | Lag of leg B behind leg A in clock cycles |
| dead_i | input | DT_W (4) | Dead time in clock cycles |
| a_hi_o | output | 1 | Leg A high-side enable |
| a_lo_o | output | 1 | Leg A low-side enable |
| b_hi_o | output | 1 | Leg B high-side enable |
| b_lo_o | output | 1 | Leg B low-side enable |

## Verification
The counter starts at zero on the edge after `en` is sampled high. Each leg's high-side then rises D+1 cycles after the start of every period. The leg stage adds one register and the dead count adds D cycles. New words first act in the period that starts after the edge on which the counter wraps. Dropping `en` forces the outputs low one edge later. Period, phase, on-time and dead-gap results are differences between edge times sampled on falling clock edges, so the fixed D+1 latency cancels. The disable, first-period and mid-period-update checks sample at the exact cycles these latencies give.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

    // Per-leg switch state
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_DEAD = 2'd1,
        LEG_HI   = 2'd2,
        LEG_LO   = 2'd3
    } leg_st_e;

    localparam int LEG_A    = 0;
    localparam int LEG_B    = 1;
    localparam int NUM_LEGS = 2;

endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase
    import psfb_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DT_W    = 4,
    parameter int PER_MIN = 20,
    parameter int PER_MAX = 48,
    parameter int DT_MAX  = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [CNT_W-1:0]    period_i,
    input  logic [CNT_W-1:0]    phase_i,
    input  logic [DT_W-1:0]     dead_i,
    output logic                act_o,
    output logic [DT_W-1:0]     dt_o,
    output logic [NUM_LEGS-1:0] cmd_o
);

    localparam logic [CNT_W-1:0] PMIN_C = CNT_W'(PER_MIN);
    localparam logic [CNT_W-1:0] PMAX_C = CNT_W'(PER_MAX);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
    localparam logic [DT_W-1:0]  DMAX_C = DT_W'(DT_MAX);
    localparam logic [DT_W-1:0]  DONE_C = DT_W'(1);

    typedef struct packed {
        logic                act;
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    per;
        logic [CNT_W-1:0]    half;
        logic [CNT_W-1:0]    phs;
        logic [DT_W-1:0]     dt;
        logic [NUM_LEGS-1:0] cmd;
    } tb_state_t;

    tb_state_t q, n;

    logic [CNT_W-1:0] per_lim;
    logic [CNT_W-1:0] pos_b;
    logic [DT_W-1:0]  dt_lim;
    logic             wrap;

    always_comb begin
        per_lim = (period_i < PMIN_C) ? PMIN_C :
                  (period_i > PMAX_C) ? PMAX_C : period_i;
        dt_lim  = (dead_i == '0)      ? DONE_C :
                  (dead_i > DMAX_C)   ? DMAX_C : dead_i;
        wrap    = (q.cnt == q.per - ONE_C);
        pos_b   = '0;
        n       = q;
        if (!en) begin
            n = '0;
        end else begin
            if (!q.act) begin
                n.act = 1'b1;
                n.cnt = '0;
                n.per = PMIN_C;
                n.dt  = dt_lim;
            end else if (wrap) begin
                n.cnt = '0;
                n.per = per_lim;
                n.dt  = dt_lim;
            end else begin
                n.cnt = q.cnt + ONE_C;
            end
            if (!q.act || wrap) begin
                n.half = n.per >> 1;
                n.phs  = (phase_i > n.half) ? n.half : phase_i;
            end
            n.cmd[LEG_A] = (n.cnt < n.half);
            pos_b = (n.cnt >= n.phs) ? (n.cnt - n.phs)
                                     : (n.cnt + (n.per - n.phs));
            n.cmd[LEG_B] = (pos_b < n.half);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign act_o = q.act;
    assign dt_o  = q.dt;
    assign cmd_o = q.cmd;

    // R3: active period always inside the allowed window
    a_r3_period_window: assert property (@(posedge clk) disable iff (rst)
        q.act |-> (q.per >= PMIN_C && q.per <= PMAX_C));

    // R4: the first period after enable runs at the shortest period
    a_r4_first_period_fast: assert property (@(posedge clk) disable iff (rst)
        $rose(q.act) |-> (q.per == PMIN_C));

    // R5: words held until the counter wraps
    a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
        (q.act && $past(q.act) && ($past(q.cnt) != $past(q.per) - ONE_C))
        |-> ($stable(q.per) && $stable(q.phs) && $stable(q.dt)));

    // R6: phase lag never exceeds half a period
    a_r6_phase_limit: assert property (@(posedge clk) disable iff (rst)
        q.act |-> (q.phs <= q.half));

    // R7: dead time stays inside its range
    a_r7_dead_range: assert property (@(posedge clk) disable iff (rst)
        q.act |-> (q.dt >= DONE_C && q.dt <= DMAX_C));

endmodule

// File: rtl/psfb_leg.sv
module psfb_leg
    import psfb_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_i,
    input  logic            cmd_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            hi_o,
    output logic            lo_o
);

    localparam logic [DT_W-1:0] ONE_C = DT_W'(1);

    typedef struct packed {
        leg_st_e         st;
        logic            side;
        logic [DT_W-1:0] hold;
    } leg_state_t;

    leg_state_t q, n;

    always_comb begin
        n = q;
        if (!run_i) begin
            n.st   = LEG_OFF;
            n.side = 1'b0;
            n.hold = '0;
        end else if (cmd_i != q.side) begin
            n.side = cmd_i;
            n.st   = LEG_DEAD;
            n.hold = dt_i - ONE_C;
        end else if (q.st == LEG_DEAD || q.st == LEG_OFF) begin
            if (q.hold == '0) begin
                n.st = q.side ? LEG_HI : LEG_LO;
            end else begin
                n.hold = q.hold - ONE_C;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: LEG_OFF, side: 1'b0, hold: '0};
        end else begin
            q <= n;
        end
    end

    assign hi_o = (q.st == LEG_HI);
    assign lo_o = (q.st == LEG_LO);

    // R9: the two switches of a leg are never on together
    a_r9_leg_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hi_o && lo_o));

    // R7: a dead cycle precedes every low-side turn-on
    a_r7_gap_before_low: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_o) |-> !$past(hi_o));

    // R7: a dead cycle precedes every high-side turn-on
    a_r7_gap_before_high: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_o) |-> !$past(lo_o));

endmodule

// File: rtl/psfb_gate_gen.sv
module psfb_gate_gen
    import psfb_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DT_W    = 4,
    parameter int PER_MIN = 20,
    parameter int DT_MAX  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic [DT_W-1:0]  dead_i,
    output logic             a_hi_o,
    output logic             a_lo_o,
    output logic             b_hi_o,
    output logic             b_lo_o
);

    localparam int PER_MAX = (PER_MIN * 12) / 5;

    logic                act;
    logic                run;
    logic [DT_W-1:0]     dt;
    logic [NUM_LEGS-1:0] cmd;
    logic [NUM_LEGS-1:0] hi;
    logic [NUM_LEGS-1:0] lo;

    psfb_timebase #(
        .CNT_W   (CNT_W),
        .DT_W    (DT_W),
        .PER_MIN (PER_MIN),
        .PER_MAX (PER_MAX),
        .DT_MAX  (DT_MAX)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .period_i (period_i),
        .phase_i  (phase_i),
        .dead_i   (dead_i),
        .act_o    (act),
        .dt_o     (dt),
        .cmd_o    (cmd)
    );

    assign run = en & act;

    for (genvar gi = 0; gi < NUM_LEGS; gi++) begin : g_leg
        psfb_leg #(
            .DT_W (DT_W)
        ) u_leg (
            .clk   (clk),
            .rst   (rst),
            .run_i (run),
            .cmd_i (cmd[gi]),
            .dt_i  (dt),
            .hi_o  (hi[gi]),
            .lo_o  (lo[gi])
        );
    end

    assign a_hi_o = hi[LEG_A];
    assign a_lo_o = lo[LEG_A];
    assign b_hi_o = hi[LEG_B];
    assign b_lo_o = lo[LEG_B];

    // R1: disable silences every output one edge later
    a_r1_idle_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));

    // R1: reset silences every output one edge later
    a_r1_idle_in_reset: assert property (@(posedge clk)
        rst |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));

endmodule

// File: tb/sim_psfb_gate_gen.sv
`timescale 1ns/1ps
module sim_psfb_gate_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] period_i = 8'd30;
    logic [7:0] phase_i  = 8'd0;
    logic [3:0] dead_i   = 4'd2;
    logic       a_hi, a_lo, b_hi, b_lo;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    psfb_gate_gen u0 (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .period_i (period_i),
        .phase_i  (phase_i),
        .dead_i   (dead_i),
        .a_hi_o   (a_hi),
        .a_lo_o   (a_lo),
        .b_hi_o   (b_hi),
        .b_lo_o   (b_lo)
    );

    // word period, word phase, word dead, expected P, expected PH, expected D
    localparam int NV = 8;
    localparam int VEC [NV][6] = '{
        '{ 30,   0,  2, 30,  0, 2},
        '{ 40,  10,  3, 40, 10, 3},
        '{ 25,  12,  1, 25, 12, 1},
        '{  5,   3,  4, 20,  3, 4},
        '{200, 100,  5, 48, 24, 5},
        '{ 40,  35,  0, 40, 20, 1},
        '{ 33,   7, 12, 33,  7, 7},
        '{ 48,   1,  7, 48,  1, 7}
    };

    int m_per_a, m_per_b, m_phs, m_hiw, m_low, m_dhl, m_dlh, m_ovl;
    int ra [4];
    int rb [4];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic observe(input int n);
        int ta, tb, tahf, talr, talf;
        logic pah, pal, pbh;
        ta = 0; tb = 0; tahf = 0; talr = 0; talf = 0;
        pah = a_hi; pal = a_lo; pbh = b_hi;
        m_ovl = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((a_hi && a_lo) || (b_hi && b_lo)) m_ovl++;
            if (a_hi && !pah) begin m_per_a = cyc - ta; ta = cyc; m_dlh = cyc - talf; end
            if (!a_hi && pah) begin tahf = cyc; m_hiw = cyc - ta; end
            if (a_lo && !pal) begin talr = cyc; m_dhl = cyc - tahf; end
            if (!a_lo && pal) begin talf = cyc; m_low = cyc - talr; end
            if (b_hi && !pbh) begin m_per_b = cyc - tb; tb = cyc; m_phs = cyc - ta; end
            pah = a_hi; pal = a_lo; pbh = b_hi;
        end
    endtask

    task automatic capture(input int n);
        int na, nb;
        logic pah, pbh;
        na = 0; nb = 0;
        pah = a_hi; pbh = b_hi;
        for (int i = 0; i < 4; i++) begin ra[i] = -1; rb[i] = -1; end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (a_hi && !pah && na < 4) begin ra[na] = cyc; na++; end
            if (b_hi && !pbh && nb < 4) begin rb[nb] = cyc; nb++; end
            pah = a_hi; pbh = b_hi;
        end
    endtask

    function automatic int outs();
        return {28'd0, a_hi, a_lo, b_hi, b_lo};
    endfunction

    initial begin
        int r0;
        // R1: reset state
        idle_cycles(3);
        chk("R1 outputs in reset", outs(), 0);
        rst = 1'b0;
        idle_cycles(2);
        chk("R1 outputs with en low", outs(), 0);

        en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            int p, ph, d;
            period_i = 8'(VEC[v][0]);
            phase_i  = 8'(VEC[v][1]);
            dead_i   = 4'(VEC[v][2]);
            p = VEC[v][3]; ph = VEC[v][4]; d = VEC[v][5];
            idle_cycles(110);
            observe(130);
            chk("R2 R3 period leg A", m_per_a, p);
            chk("R2 period leg B", m_per_b, p);
            chk("R6 phase lag", m_phs, ph);
            chk("R7 dead high-to-low", m_dhl, d);
            chk("R7 dead low-to-high", m_dlh, d);
            chk("R8 high-side on time", m_hiw, p / 2 - d);
            chk("R8 low-side on time", m_low, p - p / 2 - d);
            chk("R9 overlap cycles", m_ovl, 0);
        end

        // R1: disable, then word changes while disabled
        en = 1'b0;
        @(negedge clk);
        chk("R1 outputs one edge after en low", outs(), 0);
        for (int i = 0; i < 20; i++) begin
            period_i = 8'(21 + i);
            phase_i  = 8'(i);
            dead_i   = 4'(i % 8);
            @(negedge clk);
            if (outs() != 0) chk("R1 outputs while disabled", outs(), 0);
        end
        chk("R1 outputs after disabled word changes", outs(), 0);

        // R4: first period at the shortest period
        period_i = 8'd40; phase_i = 8'd0; dead_i = 4'd2;
        en = 1'b1;
        capture(150);
        chk("R4 first period", ra[1] - ra[0], 20);
        chk("R4 second period follows word", ra[2] - ra[1], 40);

        // R5: mid-period update waits for the period boundary
        period_i = 8'd30; phase_i = 8'd5; dead_i = 4'd2;
        idle_cycles(120);
        r0 = -1;
        while (r0 < 0) begin
            logic p_prev;
            p_prev = a_hi;
            @(negedge clk);
            if (a_hi && !p_prev) r0 = cyc;
        end
        period_i = 8'd44; phase_i = 8'd10;
        capture(120);
        chk("R5 current period keeps old word", ra[0] - r0, 30);
        chk("R5 next period uses new word", ra[1] - ra[0], 44);
        chk("R5 current phase keeps old word", rb[0] - r0, 5);
        chk("R5 next phase uses new word", rb[1] - ra[0], 10);

        // R1: reset while running
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 outputs one edge after reset", outs(), 0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule